// File: doc/BRIEF.md
# Per-Core Interrupt Intake and Arbiter

This block sits beside one processor core and takes in interrupt messages already addressed to that core. Each message carries a 3-bit delivery mode, an 8-bit vector and a trigger flag. Vectored messages are stored as request bits, one per vector, in a request register. The four non-vectored kinds each go into a dedicated one-deep pending slot that keeps a copy of the vector.

From this state the block works out, with no clock in the path, whether the core should be interrupted now. It also gives the kind and the vector of the winning source. The non-vectored sources come first, in a fixed order. The vectored path is gated by the core's interrupt-enable flag, by the task-priority class and by the highest vector already in service.

When the core pulses its acknowledge, the winning source is retired. A non-vectored slot is emptied. A vectored winner moves from the request register to the in-service register. Ending service (EOI) is handled elsewhere.

Top module: `irq_accept_arb`

## Requirements
- R1: The message mode codes are 0 Fixed, 1 LowestPriority, 2 SMI, 4 NMI, 5 INIT and 7 ExtInt. A message with code 3 or 6 changes no state and has no effect on any output.
- R2: A mode-0 or mode-1 message sets the request bit of its vector. It sets that vector's trigger bit when `msg_level` is 1 and clears it when `msg_level` is 0. While a vectored interrupt is offered, `irq_level` shows the trigger bit of the offered vector.
- R3: Each non-vectored kind holds at most one pending message. A further message of a kind that is already pending is dropped, and the stored vector is kept.
- R4: While SMI, NMI or INIT is pending, `irq_req` is 1 whatever the value of `int_enable`.
- R5: A pending ExtInt raises `irq_req` only while `int_enable` is 1.
- R6: A vectored interrupt is offered only when all of the following hold: `int_enable` is 1; some request bit is set; the highest requested vector is above the highest in-service vector, or nothing is in service; and bits 7:4 of that vector are greater than bits 7:4 of `task_prio`.
- R7: The winner is chosen in the order SMI, NMI, INIT, ExtInt, vectored. `irq_kind` encodes it as 1 SMI, 2 NMI, 3 INIT, 4 ExtInt and 5 vectored, and is 0 when `irq_req` is 0.
- R8: `irq_vector` carries the stored vector for NMI, INIT and ExtInt, and the highest requested vector on the vectored path. It is 0 for SMI and when nothing is offered.
- R9: An acknowledge while `irq_req` is 1 retires only the winner. A slot winner has its pending flag cleared. A vectored winner moves from request to in-service, and the next highest request is considered from then on.
- R10: An acknowledge while `irq_req` is 0 changes no state.
- R11: A message that arrives in the same cycle as the acknowledge retiring its own slot or vector is applied after the retirement, so it becomes pending again.
- R12: Synchronous active-high reset clears every slot, every stored vector, and the request, in-service and trigger registers. Messages and acknowledges take effect at the next rising edge. The outputs follow from the registered state with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message strobe, one cycle per message |
| msg_mode | input | 3 | Delivery mode code |
| msg_vector | input | 8 | Message vector |
| msg_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| int_enable | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task priority value, bits 7:4 used as class |
| ack | input | 1 | Core takes the offered interrupt |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_kind | output | 3 | Kind of the winner |
| irq_vector | output | 8 | Vector of the winner |
| irq_level | output | 1 | Trigger bit of the offered vectored interrupt |

## Verification
A message or acknowledge driven in one cycle is registered at the next rising edge. Its effect on `irq_req`, `irq_kind`, `irq_vector` and `irq_level` is therefore due right after that edge, with no additional register stage. A change on `int_enable` or `task_prio` shows on the outputs in the same cycle. The bench drives inputs on the falling edge, updates its behavioural model on the rising edge from the same input values, and compares every output 3 ns after each rising edge, while the inputs are still steady. Directed checks read the outputs on the falling edge, before any input is changed.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_SMI   = 3'd1,
    K_NMI   = 3'd2,
    K_INIT  = 3'd3,
    K_EXT   = 3'd4,
    K_FIXED = 3'd5
  } kind_e;

  // Slot index doubles as arbitration rank: 0 wins first
  localparam int NSLOT = 4;

  function automatic dmode_e slot_mode(input int s);
    case (s)
      0:       return DM_SMI;
      1:       return DM_NMI;
      2:       return DM_INIT;
      default: return DM_EXT;
    endcase
  endfunction

  function automatic kind_e slot_kind(input int s);
    case (s)
      0:       return K_SMI;
      1:       return K_NMI;
      2:       return K_INIT;
      default: return K_EXT;
    endcase
  endfunction

endpackage

// File: rtl/irq_msb_index.sv
module irq_msb_index #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits_in,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Ascending scan, last hit wins: index of the highest set bit
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (bits_in[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_nv_slot.sv
module irq_nv_slot #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clr,
  input  logic [VW-1:0] vec_in,
  output logic          pend,
  output logic [VW-1:0] vec_out
);
  // Clear is applied first; a load in the same cycle refills the slot
  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      vec_out <= '0;
    end else if (load && (!pend || clr)) begin
      pend    <= 1'b1;
      vec_out <= vec_in;
    end else if (clr) begin
      pend    <= 1'b0;
    end
  end

  AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (rst)
    pend && load && !clr |=> pend && (vec_out == $past(vec_out))); // R3
  AST_SLOT_CLR: assert property (@(posedge clk) disable iff (rst)
    clr && !load |=> !pend); // R9
  AST_SLOT_REFILL: assert property (@(posedge clk) disable iff (rst)
    clr && load |=> pend && (vec_out == $past(vec_in))); // R11
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
  import irq_pkg::*;
#(
  parameter int NVEC  = 256,
  parameter int TPR_W = 8,
  parameter int PCLS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     msg_valid,
  input  logic [2:0]               msg_mode,
  input  logic [$clog2(NVEC)-1:0]  msg_vector,
  input  logic                     msg_level,
  input  logic                     int_enable,
  input  logic [TPR_W-1:0]         task_prio,
  input  logic                     ack,
  output logic                     irq_req,
  output logic [2:0]               irq_kind,
  output logic [$clog2(NVEC)-1:0]  irq_vector,
  output logic                     irq_level
);
  localparam int VW = $clog2(NVEC);

  dmode_e          mode_w;
  kind_e           kind_w;
  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] irr_d, isr_d, tmr_d;
  logic [VW-1:0]   irr_top, isr_top;
  logic            irr_any, isr_any;
  logic [NSLOT-1:0] pend;
  logic [VW-1:0]   svec [NSLOT];
  logic            fixed_ok, ext_ok, take, vec_msg;

  assign mode_w  = dmode_e'(msg_mode);
  assign vec_msg = msg_valid && (mode_w == DM_FIXED || mode_w == DM_LOWEST);

  irq_msb_index #(.W(NVEC), .IW(VW)) u_irr_top (
    .bits_in(irr_q), .idx(irr_top), .any(irr_any));
  irq_msb_index #(.W(NVEC), .IW(VW)) u_isr_top (
    .bits_in(isr_q), .idx(isr_top), .any(isr_any));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    irq_nv_slot #(.VW(VW)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .load    (msg_valid && (mode_w == slot_mode(s))),
      .clr     (take && (kind_w == slot_kind(s))),
      .vec_in  (msg_vector),
      .pend    (pend[s]),
      .vec_out (svec[s])
    );
  end

  // Offer decision
  assign fixed_ok = int_enable && irr_any &&
                    (!isr_any || (irr_top > isr_top)) &&
                    (irr_top[VW-1 -: PCLS] > task_prio[TPR_W-1 -: PCLS]);
  assign ext_ok   = int_enable && pend[3];
  assign irq_req  = (|pend[2:0]) || ext_ok || fixed_ok;
  assign take     = ack && irq_req;

  always_comb begin
    if (pend[0])       kind_w = K_SMI;
    else if (pend[1])  kind_w = K_NMI;
    else if (pend[2])  kind_w = K_INIT;
    else if (ext_ok)   kind_w = K_EXT;
    else if (fixed_ok) kind_w = K_FIXED;
    else               kind_w = K_NONE;
  end

  always_comb begin
    irq_level = 1'b0;
    case (kind_w)
      K_NMI:   irq_vector = svec[1];
      K_INIT:  irq_vector = svec[2];
      K_EXT:   irq_vector = svec[3];
      K_FIXED: begin
        irq_vector = irr_top;
        irq_level  = tmr_q[irr_top];
      end
      default: irq_vector = '0;
    endcase
  end

  assign irq_kind = kind_w;

  // Vectored state: retire first, then accept the new request
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (take && kind_w == K_FIXED) begin
      irr_d[irr_top] = 1'b0;
      isr_d[irr_top] = 1'b1;
    end
    if (vec_msg) begin
      irr_d[msg_vector] = 1'b1;
      tmr_d[msg_vector] = msg_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  AST_RSVD_DROP: assert property (@(posedge clk) disable iff (rst)
    msg_valid && (msg_mode == 3'd3 || msg_mode == 3'd6) && !ack
    |=> (irr_q == $past(irr_q)) && (pend == $past(pend))); // R1
  AST_LEVEL_STORE: assert property (@(posedge clk) disable iff (rst)
    vec_msg |=> irr_q[$past(msg_vector)] &&
                (tmr_q[$past(msg_vector)] == $past(msg_level))); // R2
  AST_UNMASK_FIRES: assert property (@(posedge clk) disable iff (rst)
    msg_valid && (msg_mode == 3'd2 || msg_mode == 3'd4 || msg_mode == 3'd5)
    |=> irq_req); // R4
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    !int_enable |-> (irq_kind != 3'd4) && (irq_kind != 3'd5)); // R5
  AST_FIXED_CLASS: assert property (@(posedge clk) disable iff (rst)
    irq_kind == 3'd5 |-> irq_vector[VW-1 -: PCLS] > task_prio[TPR_W-1 -: PCLS]); // R6
  AST_KIND_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_kind != 3'd0)); // R7
  AST_ISR_MOVE: assert property (@(posedge clk) disable iff (rst)
    ack && irq_kind == 3'd5 && !msg_valid
    |=> isr_q[$past(irr_top)] && !irr_q[$past(irr_top)]); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    ack && !irq_req && !msg_valid
    |=> (irr_q == $past(irr_q)) && (isr_q == $past(isr_q)) &&
        (pend == $past(pend))); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !irq_req && (irr_q == '0) && (isr_q == '0)); // R12
endmodule

// File: tb/sim_irq_accept_arb.sv
`timescale 1ns/1ps
module sim_irq_accept_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       msg_valid = 1'b0;
  logic [2:0] msg_mode = '0;
  logic [7:0] msg_vector = '0;
  logic       msg_level = 1'b0;
  logic       int_enable = 1'b0;
  logic [7:0] task_prio = '0;
  logic       ack = 1'b0;
  logic       irq_req, irq_level;
  logic [2:0] irq_kind;
  logic [7:0] irq_vector;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string phase = "R12";

  always #4 clk = ~clk;

  irq_accept_arb u0 (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_mode(msg_mode),
    .msg_vector(msg_vector), .msg_level(msg_level), .int_enable(int_enable),
    .task_prio(task_prio), .ack(ack), .irq_req(irq_req), .irq_kind(irq_kind),
    .irq_vector(irq_vector), .irq_level(irq_level));

  // Behavioural reference
  logic [255:0] m_irr, m_isr, m_tmr;
  bit           m_p [4];
  int           m_v [4];

  function automatic int top_of(input logic [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  task automatic calc(output bit r, output int k, output int v, output bit l, output int it);
    int is;
    bit fx;
    it = top_of(m_irr);
    is = top_of(m_isr);
    fx = int_enable && it >= 0 && it > is && (it / 16) > (int'(task_prio) / 16);
    k = 0; v = 0; l = 0;
    if (m_p[0])                  k = 1;
    else if (m_p[1])             begin k = 2; v = m_v[1]; end
    else if (m_p[2])             begin k = 3; v = m_v[2]; end
    else if (int_enable && m_p[3]) begin k = 4; v = m_v[3]; end
    else if (fx)                 begin k = 5; v = it; l = m_tmr[it]; end
    r = (k != 0);
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit r, l;
    int k, v, it, slot;
    if (rst) begin
      m_irr = '0; m_isr = '0; m_tmr = '0;
      for (int s = 0; s < 4; s++) begin m_p[s] = 0; m_v[s] = 0; end
    end else begin
      calc(r, k, v, l, it);
      if (ack && r) begin
        if (k == 5) begin m_irr[it] = 1'b0; m_isr[it] = 1'b1; end
        else m_p[k-1] = 0;
      end
      if (msg_valid) begin
        slot = -1;
        case (msg_mode)
          3'd0, 3'd1: begin m_irr[msg_vector] = 1'b1; m_tmr[msg_vector] = msg_level; end
          3'd2: slot = 0;
          3'd4: slot = 1;
          3'd5: slot = 2;
          3'd7: slot = 3;
          default: ;
        endcase
        if (slot >= 0 && !m_p[slot]) begin m_p[slot] = 1; m_v[slot] = msg_vector; end
      end
    end
    #3;
    if (!rst && !done) begin
      calc(r, k, v, l, it);
      chk(phase, irq_req, r, "irq_req");
      chk(phase, irq_kind, k, "irq_kind");
      chk(phase, irq_vector, v, "irq_vector");
      chk(phase, irq_level, l, "irq_level");
    end
  end

  task automatic send(input int mode, input int vec, input bit lvl, input bit a);
    msg_valid = 1'b1; msg_mode = 3'(mode); msg_vector = 8'(vec);
    msg_level = lvl; ack = a;
    @(negedge clk);
    msg_valid = 1'b0; ack = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit r, input int k, input int v);
    chk(req, irq_req, r, "req");
    chk(req, irq_kind, k, "kind");
    chk(req, irq_vector, v, "vector");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R12", 0, 0, 0);

    phase = "R1";
    int_enable = 1'b1; task_prio = 8'h00;
    send(3, 8'h50, 0, 0);
    send(6, 8'h60, 1, 0);
    @(negedge clk);
    expect_out("R1", 0, 0, 0);

    phase = "R6";
    int_enable = 1'b0;
    send(0, 8'h45, 0, 0);
    expect_out("R6", 0, 0, 0);
    int_enable = 1'b1; task_prio = 8'h30;
    @(negedge clk);
    expect_out("R6", 1, 5, 8'h45);
    chk("R2", irq_level, 0, "edge level");
    task_prio = 8'h4F;
    @(negedge clk);
    expect_out("R6", 0, 0, 0);
    task_prio = 8'h30;

    phase = "R2";
    send(1, 8'h80, 1, 0);
    expect_out("R2", 1, 5, 8'h80);
    chk("R2", irq_level, 1, "level trigger");

    phase = "R9";
    pulse_ack();
    expect_out("R9", 0, 0, 0);
    send(0, 8'h90, 0, 0);
    expect_out("R9", 1, 5, 8'h90);
    pulse_ack();
    expect_out("R9", 0, 0, 0);

    phase = "R4";
    int_enable = 1'b0;
    send(4, 8'h22, 0, 0);
    expect_out("R4", 1, 2, 8'h22);
    phase = "R3";
    send(4, 8'h33, 0, 0);
    expect_out("R3", 1, 2, 8'h22);
    phase = "R7";
    send(2, 8'h77, 0, 0);
    expect_out("R8", 1, 1, 0);
    send(5, 8'h11, 0, 0);
    send(7, 8'h99, 0, 0);
    expect_out("R7", 1, 1, 0);
    pulse_ack();
    expect_out("R7", 1, 2, 8'h22);
    pulse_ack();
    expect_out("R7", 1, 3, 8'h11);
    pulse_ack();
    expect_out("R5", 0, 0, 0);

    phase = "R10";
    pulse_ack();
    expect_out("R10", 0, 0, 0);
    int_enable = 1'b1;
    @(negedge clk);
    expect_out("R10", 1, 4, 8'h99);

    phase = "R11";
    int_enable = 1'b0;
    send(4, 8'h44, 0, 0);
    expect_out("R11", 1, 2, 8'h44);
    send(4, 8'h55, 0, 1);
    expect_out("R11", 1, 2, 8'h55);
    pulse_ack();
    int_enable = 1'b1;
    @(negedge clk);
    expect_out("R5", 1, 4, 8'h99);
    pulse_ack();
    expect_out("R9", 0, 0, 0);

    phase = "R12";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R12", 0, 0, 0);
    task_prio = 8'h00;
    send(0, 8'h20, 0, 0);
    expect_out("R12", 1, 5, 8'h20);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule